// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing side of a small UART. It decodes four 32-bit, word-aligned registers in a 16-byte window. The registers are receive data, transmit data, status and control. An 8-deep byte queue holds received bytes. The serial side hands bytes in over a valid/ready stream, and `rx_ready` stays high while the queue has room. A byte offered while `rx_ready` is low is not taken and is lost. A transmit write becomes a one-cycle byte strobe on `tx_valid`/`tx_data`. There is no ready on the transmit side, because the transmitter is treated as always idle.

The status register reports queue occupancy, a constant "transmitter empty" flag and a sticky event flag. The event flag is raised by a transmit write or by a non-empty receive queue, and a status read clears it. The interrupt output is that flag gated by an enable bit in the control register. Bus accesses take a single cycle: `bus_valid` marks the access, `bus_write` gives its direction and `bus_addr[3:2]` selects the register. Read data is registered and appears on `bus_rdata` in the cycle after the read.

Top module: `uart_regif`

## Requirements
- R1: `bus_addr[3:2]` selects the register: 0 receive data, 1 transmit data, 2 status, 3 control. A read loads `bus_rdata` at the next clock edge, and `bus_rdata` otherwise holds its value. A read of the transmit register returns 0.
- R2: A receive-data read returns the oldest queued byte, zero-extended, and removes it. A read of an empty queue returns 0 and leaves the occupancy at zero. Bytes come out in arrival order.
- R3: An input byte is taken on a clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is high exactly while fewer than 8 bytes are queued. A byte offered while 8 are queued is dropped.
- R4: The status word holds the values from before the access. Bit0 is set when the queue is non-empty, bit1 when it holds 8 bytes, bit2 always reads 1, bit3 always reads 0, and bit4 is the event flag. Bits 31:5 read 0.
- R5: A write to the transmit register pulses `tx_valid` high for exactly one cycle, in the cycle after the write, with `tx_data` equal to `bus_wdata[7:0]`. `tx_valid` is low at all other times.
- R6: The event flag is sticky. A transmit write sets it, and it is set whenever the queue is non-empty. A status read clears it, but only once the queue is empty.
- R7: A control write stores `bus_wdata[7:0]`, and a control read returns it zero-extended. Control bit1 empties the queue, and it wins over a byte arriving in the same cycle. Control bit0 has no effect other than being stored.
- R8: `irq` is high exactly when the event flag and control bit4 are both set.
- R9: Writes to the status register and to the receive-data register change nothing: not the queue, the event flag, the control value nor `irq`.
- R10: A synchronous active-high reset empties the queue and clears the control value, the event flag, `irq`, `tx_valid` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue has room; a byte is taken when valid and ready |
| tx_valid | output | 1 | One-cycle outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| irq | output | 1 | Level interrupt |

## Verification
The queue is driven with single bytes, with bursts that fill it and overrun it by one, and with bytes that arrive in the same cycle as a pop or a queue-clear write. These patterns separate the ordering, the drop rule and the clear priority. Status reads are placed before and after the queue drains, which shows the event flag's stickiness apart from its link to occupancy. A long random mix of reads, writes and stream traffic is then compared against a behavioural queue model on every clock, and a reset is applied with bytes still queued.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_RXD  = 2'd0,
    REG_TXD  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int ST_RXV  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_TXF  = 3;
  localparam int ST_PEND = 4;

  localparam int CT_TXRST = 0;
  localparam int CT_RXRST = 1;
  localparam int CT_IE    = 4;

  typedef struct packed {
    logic rd_rxd;
    logic rd_txd;
    logic rd_stat;
    logic rd_ctrl;
    logic wr_rxd;
    logic wr_txd;
    logic wr_stat;
    logic wr_ctrl;
  } acc_t;
endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  localparam int NREG = 1 << REG_AW;

  logic [NREG-1:0] hit;
  logic [NREG-1:0] rd;
  logic [NREG-1:0] wr;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign hit[g] = valid && (addr[REG_AW+1:2] == REG_AW'(g));
    assign rd[g]  = hit[g] && !write;
    assign wr[g]  = hit[g] && write;
  end

  always_comb begin
    acc.rd_rxd  = rd[REG_RXD];
    acc.rd_txd  = rd[REG_TXD];
    acc.rd_stat = rd[REG_STAT];
    acc.rd_ctrl = rd[REG_CTRL];
    acc.wr_rxd  = wr[REG_RXD];
    acc.wr_txd  = wr[REG_TXD];
    acc.wr_stat = wr[REG_STAT];
    acc.wr_ctrl = wr[REG_CTRL];
  end
endmodule

// File: rtl/uart_regif_rxq.sv
module uart_regif_rxq #(
  parameter  int DEPTH  = 8,
  parameter  int BYTE_W = 8,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] head,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_nxt,
  output logic              full
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp_q;
  logic [PTR_W-1:0]  rp_q;
  logic              push_ok;
  logic              pop_ok;

  assign full    = (cnt_q == FULL_CNT);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && (cnt_q != '0) && !clr;
  assign head    = mem[rp_q];

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wp_q == PTR_W'(g))) mem[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(push_ok);
      rp_q  <= rp_q + PTR_W'(pop_ok);
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/uart_regif_stat.sv
module uart_regif_stat
  import uart_regif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_t              acc,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              q_nz,
  input  logic              q_full,
  input  logic              q_nxt_nz,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              pend_q,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (acc.rd_stat) pend_d = 1'b0;
    if (acc.wr_txd)  pend_d = 1'b1;
    if (q_nxt_nz)    pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (acc.wr_ctrl) ctrl_q <= ctrl_in;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_RXV]  = q_nz;
    status[ST_RXF]  = q_full;
    status[ST_TXE]  = 1'b1;
    status[ST_TXF]  = 1'b0;
    status[ST_PEND] = pend_q;
  end

  assign irq = pend_q && ctrl_q[CT_IE];
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int BYTE_W    = 8,
  parameter int RXQ_DEPTH = 8,
  parameter int CTRL_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  localparam int CNT_W = $clog2(RXQ_DEPTH + 1);

  acc_t              acc;
  reg_sel_e          sel;
  logic              q_clr;
  logic [BYTE_W-1:0] q_head;
  logic [CNT_W-1:0]  rxq_cnt;
  logic [CNT_W-1:0]  rxq_nxt;
  logic              q_full;
  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rd_mux;

  uart_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid (bus_valid),
    .write (bus_write),
    .addr  (bus_addr),
    .acc   (acc)
  );

  assign q_clr = acc.wr_ctrl && bus_wdata[CT_RXRST];

  uart_regif_rxq #(.DEPTH(RXQ_DEPTH), .BYTE_W(BYTE_W)) u_rxq (
    .clk     (clk),
    .rst     (rst),
    .clr     (q_clr),
    .push    (rx_valid),
    .pop     (acc.rd_rxd),
    .din     (rx_data),
    .head    (q_head),
    .cnt_q   (rxq_cnt),
    .cnt_nxt (rxq_nxt),
    .full    (q_full)
  );

  uart_regif_stat #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .ctrl_in  (bus_wdata[CTRL_W-1:0]),
    .q_nz     (rxq_cnt != '0),
    .q_full   (q_full),
    .q_nxt_nz (rxq_nxt != '0),
    .ctrl_q   (ctrl_q),
    .pend_q   (pend_q),
    .status   (status),
    .irq      (irq)
  );

  assign rx_ready = !q_full;
  assign sel      = reg_sel_e'(bus_addr[REG_AW+1:2]);

  always_comb begin
    unique case (sel)
      REG_RXD:  rd_mux = (rxq_cnt != '0) ? DATA_W'(q_head) : '0;
      REG_TXD:  rd_mux = '0;
      REG_STAT: rd_mux = status;
      REG_CTRL: rd_mux = DATA_W'(ctrl_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (bus_valid && !bus_write) bus_rdata <= rd_mux;
      tx_valid <= acc.wr_txd;
      if (acc.wr_txd) tx_data <= bus_wdata[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int BYTE_W    = 8,
  parameter int RXQ_DEPTH = 8,
  parameter int CTRL_W    = 8,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              pend,
  input logic [CTRL_W-1:0] ctrl
);
  logic wr_tx, wr_st, wr_ct, rd_rx;
  assign wr_tx = bus_valid && bus_write && (bus_addr[3:2] == 2'd1);
  assign wr_st = bus_valid && bus_write && (bus_addr[3:2] == 2'd2);
  assign wr_ct = bus_valid && bus_write && (bus_addr[3:2] == 2'd3);
  assign rd_rx = bus_valid && !bus_write && (bus_addr[3:2] == 2'd0);

  p_empty_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_rx && (cnt == '0) |=> (bus_rdata == '0) && (cnt <= CNT_W'(1)));

  p_drop_full_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid && !rx_ready && !rd_rx && !wr_ct |=> !rx_ready);

  p_tx_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> tx_valid && (tx_data == $past(bus_wdata[BYTE_W-1:0])));

  p_tx_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_tx |=> !tx_valid);

  p_pend_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> pend);

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ct && bus_wdata[1] |=> (cnt == '0));

  p_irq_tx_r8: assert property (@(posedge clk) disable iff (rst)
    wr_tx && ctrl[4] |=> irq);

  p_stat_wr_r9: assert property (@(posedge clk) disable iff (rst)
    wr_st && !rx_valid |=> $stable(cnt) && $stable(ctrl));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> !irq && !tx_valid && (cnt == '0) && (bus_rdata == '0));
endmodule

bind uart_regif uart_regif_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W),
  .RXQ_DEPTH(RXQ_DEPTH), .CTRL_W(CTRL_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .irq(irq), .cnt(rxq_cnt), .pend(pend_q), .ctrl(ctrl_q)
);

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  always #10 clk = ~clk;

  uart_regif dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // behavioural reference model
  logic [7:0]  mq[$];
  bit          m_pend = 0;
  logic [7:0]  m_ctrl = '0;
  logic [31:0] m_rd   = '0;
  bit          m_txv  = 0;
  logic [7:0]  m_txd  = '0;
  int          m_sel  = 0;
  bit          m_en   = 0;
  bit          m_push;
  logic [31:0] m_st;
  int          m_a;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_pend = 0; m_ctrl = '0; m_rd = '0; m_txv = 0; m_en = 1;
    end else begin
      m_a    = int'(bus_addr[3:2]);
      m_push = rx_valid && (mq.size() < 8);
      m_st   = 32'h4 | (m_pend ? 32'h10 : 0) | ((mq.size() == 8) ? 32'h2 : 0)
               | ((mq.size() != 0) ? 32'h1 : 0);
      m_txv  = 0;
      if (bus_valid && !bus_write) begin
        m_sel = m_a;
        case (m_a)
          0: m_rd = (mq.size() != 0) ? {24'h0, mq.pop_front()} : 32'h0;
          1: m_rd = 32'h0;
          2: begin m_rd = m_st; m_pend = 0; end
          default: m_rd = {24'h0, m_ctrl};
        endcase
      end
      if (bus_valid && bus_write) begin
        if (m_a == 1) begin m_txv = 1; m_txd = bus_wdata[7:0]; m_pend = 1; end
        if (m_a == 3) begin
          m_ctrl = bus_wdata[7:0];
          if (bus_wdata[1]) begin mq.delete(); m_push = 0; end
        end
      end
      if (m_push) mq.push_back(rx_data);
      if (mq.size() != 0) m_pend = 1;
    end
  end

  always @(negedge clk) begin
    if (m_en) begin
      case (m_sel)
        0: chk("R2 rdata", bus_rdata, m_rd);
        1: chk("R1 rdata", bus_rdata, m_rd);
        2: chk("R4 rdata", bus_rdata, m_rd);
        default: chk("R7 rdata", bus_rdata, m_rd);
      endcase
      chk("R3 rx_ready", {31'h0, rx_ready}, {31'h0, mq.size() < 8});
      chk("R8 irq", {31'h0, irq}, {31'h0, m_pend && m_ctrl[4]});
      chk("R5 tx_valid", {31'h0, tx_valid}, {31'h0, m_txv});
      if (m_txv) chk("R5 tx_data", {24'h0, tx_data}, {24'h0, m_txd});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      report();
    end
  end

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    bus_valid = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic push_bytes(int n, logic [7:0] first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = first + 8'(i);
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset rdata", bus_rdata, 32'h0);
    chk("R10 reset irq", {31'h0, irq}, 32'h0);
    rst = 0;
    rd(4'h0C, 32'h0, "R10 ctrl after reset");
    rd(4'h08, 32'h04, "R10 R4 status after reset");
    rd(4'h04, 32'h0, "R1 tx register reads zero");

    push_bytes(9, 8'h01);
    rd(4'h08, 32'h17, "R3 R4 status full");
    wr(4'h08, 32'hFF);
    wr(4'h00, 32'h5A);
    rd(4'h0C, 32'h0, "R9 ctrl unchanged");
    rd(4'h08, 32'h17, "R9 status unchanged");
    for (int i = 1; i <= 8; i++) rd(4'h00, 32'(i), "R2 fifo order");
    rd(4'h00, 32'h0, "R2 empty read");
    rd(4'h08, 32'h14, "R6 pending sticky");
    rd(4'h08, 32'h04, "R6 pending cleared");

    wr(4'h0C, 32'h11);
    rd(4'h0C, 32'h11, "R7 ctrl readback");
    chk("R8 irq idle", {31'h0, irq}, 32'h0);
    wr(4'h04, 32'h1A5);
    chk("R8 irq after tx", {31'h0, irq}, 32'h1);
    rd(4'h08, 32'h14, "R5 tx sets pending");
    chk("R8 irq cleared", {31'h0, irq}, 32'h0);

    push_bytes(3, 8'h40);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 4'h0C; bus_wdata = 32'h12;
    rx_valid = 1; rx_data = 8'h77;
    @(negedge clk);
    bus_valid = 0; rx_valid = 0;
    rd(4'h08, 32'h14, "R7 clear wins over push");
    rd(4'h08, 32'h04, "R6 pending drops after clear");

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bus_valid = $urandom_range(0, 1) == 1;
      bus_write = $urandom_range(0, 2) == 0;
      bus_addr  = 4'($urandom_range(0, 3) << 2);
      bus_wdata = $urandom;
      if (bus_addr == 4'hC && bus_write && $urandom_range(0, 7) != 0)
        bus_wdata[1] = 1'b0;
      rx_valid  = $urandom_range(0, 2) != 0;
      rx_data   = 8'($urandom);
    end
    @(negedge clk);
    bus_valid = 0; rx_valid = 0;

    push_bytes(4, 8'h90);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R10 mid reset ready", {31'h0, rx_ready}, 32'h1);
    rd(4'h08, 32'h04, "R10 mid reset status");
    rd(4'h00, 32'h0, "R10 mid reset fifo empty");
    repeat (2) @(negedge clk);
    report();
  end
endmodule